// File: doc/BRIEF.md
# Virtual Address Region Decoder and Access Checker

This block sits between the load/store and fetch units of a 32-bit core and its translation lookaside buffer. For every access it receives the virtual address, the access kind, the current privilege mode, the global translation-enable bit, and the fields of whatever entry the TLB looked up. From these it produces the physical address, the read/write/execute grant flags and a fault code, all combinationally in the same cycle.

The upper address space holds fixed windows that are never translated. Two of them map straight onto the low 512 MB, and the topmost region passes through unchanged. In user mode these windows are closed, apart from a 64 MB slice at the bottom of the top region. Every other address is either stripped of its top three bits (translation disabled) or checked against the TLB entry. The TLB checks run in a fixed order: multiple hit, miss, user protection, write permission, then the dirty bit. The first one that fails sets the fault code.

The page-table-entry high register (`pteh`) is the only state in the block. After any fault except a multiple hit, it records the faulting page number so that a refill handler can find it. The address-space identifier in its low byte is left as it was. The interface is a plain per-cycle strobe with no back-pressure. The block has no ready signal. It evaluates any access presented with `acc_valid` high and never stalls it.

Top module: `mac_addr_check`

## Requirements
- R1: In privileged mode, an address in 0x8000_0000..0xBFFF_FFFF gives fault 0, `pa` = address with bits 31:29 cleared, all three permissions and `pa_valid` high, whatever the TLB inputs and `xlat_en` are.
- R2: In privileged mode, an address at or above 0xE000_0000 gives fault 0, `pa` = the address unchanged and all three permissions. In user mode the same holds inside 0xE000_0000..0xE3FF_FFFF.
- R3: In user mode, an address in 0x8000_0000..0xBFFF_FFFF, or in 0xE400_0000..0xFFFF_FFFF, faults with code 0x100 for a write and 0x0E0 for a read or fetch. `acc_kind` encodes read=0, write=1, fetch=2; the value 3 behaves as a read.
- R4: With `xlat_en` low, any other address gives fault 0, `pa` = address with bits 31:29 cleared, and all three permissions.
- R5: With translation on in a translated region, `tlb_multi` high gives fault 0x140, ahead of every other TLB check.
- R6: If there is no multiple hit and `tlb_hit` is low, the fault is 0x060 for a write and 0x040 for a read or fetch.
- R7: On a single hit in user mode with `tlb_prot[1]` (user access) clear, the fault is 0x0C0 for a write and 0x0A0 for a read or fetch.
- R8: A write that passes R7 faults with 0x0C0 when `tlb_prot[0]` (write allowed) is clear. Otherwise it faults with 0x080 when `tlb_dirty` is clear.
- R9: On a translated success, `pa` = (`tlb_ppn` << 10) with its low bits replaced by the address's page offset. `tlb_size` sets the page size: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB.
- R10: On a translated success, read and execute are granted. Write is granted only when `tlb_prot[0]` and `tlb_dirty` are both set.
- R11: Whenever `acc_valid` is low or the fault code is non-zero, `pa`, all permissions and `pa_valid` are 0. With `acc_valid` low the fault code is 0 as well.
- R12: `pteh` resets to 0 and has the layout {page number[31:10], 2'b00, ASID[7:0]}. `pteh_we` loads the page number and ASID from `pteh_wdata` and takes priority. Otherwise, a valid access with a non-zero fault other than 0x140 loads address bits 31:10 into the page-number field on the next edge and keeps the ASID. All other cycles, a multiple-hit fault included, leave `pteh` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the `pteh` register |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Virtual address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| priv_mode | input | 1 | 1 = privileged mode |
| xlat_en | input | 1 | Global address translation enable |
| tlb_hit | input | 1 | TLB found exactly one or more matching entries |
| tlb_multi | input | 1 | TLB found more than one matching entry |
| tlb_ppn | input | 19 | Physical page number of the hit entry |
| tlb_size | input | 2 | Page size code of the hit entry |
| tlb_prot | input | 2 | Bit 1 user access allowed, bit 0 write allowed |
| tlb_dirty | input | 1 | Dirty bit of the hit entry |
| pteh_we | input | 1 | Load `pteh` from `pteh_wdata` |
| pteh_wdata | input | 32 | New `pteh` contents |
| pa | output | 32 | Physical address |
| pa_valid | output | 1 | Access valid and fault-free |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| fault_code | output | 12 | Exception code, 0 when none |
| pteh | output | 32 | Page-table-entry high register |

## Verification
The bench targets the edges of the user window at 0xE3FF_FFFF/0xE400_0000 and the region boundaries at 0x7FFF_FFFF, 0xBFFF_FFFF, 0xC000_0000 and 0xDFFF_FFFF. A decoder that is off by one region there would either open privileged space to user code or raise address errors on legal accesses. It also drives combinations where several TLB checks fail together, such as a multiple hit with the miss flag low and prot clear, or a write with both prot bit 0 and dirty clear. A wrong check order shows up as the wrong fault code. The bench steps through all four page sizes with offsets that have high bits set, which catches a mis-sized offset mask. It also confirms that a multiple hit leaves `pteh` untouched while every other fault rewrites only its page-number field.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int FC_W = 12;

  localparam logic [FC_W-1:0] FC_NONE     = 12'h000;
  localparam logic [FC_W-1:0] FC_RD_MISS  = 12'h040;
  localparam logic [FC_W-1:0] FC_WR_MISS  = 12'h060;
  localparam logic [FC_W-1:0] FC_FIRST_WR = 12'h080;
  localparam logic [FC_W-1:0] FC_RD_PROT  = 12'h0A0;
  localparam logic [FC_W-1:0] FC_WR_PROT  = 12'h0C0;
  localparam logic [FC_W-1:0] FC_RD_ADDR  = 12'h0E0;
  localparam logic [FC_W-1:0] FC_WR_ADDR  = 12'h100;
  localparam logic [FC_W-1:0] FC_MULTI    = 12'h140;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  localparam perm_t PERM_NONE = '{r: 1'b0, w: 1'b0, x: 1'b0};
  localparam perm_t PERM_ALL  = '{r: 1'b1, w: 1'b1, x: 1'b1};

  // extra offset bits above the base page for each page size code
  function automatic int unsigned size_extra(input int unsigned code);
    case (code)
      0:       return 0;
      1:       return 2;
      2:       return 6;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/mac_region_dec.sv
module mac_region_dec #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  output logic              fixed_map,
  output logic              strip_top,
  output logic              user_block
);
  localparam logic [2:0] SEG_LOW_A = 3'b100;
  localparam logic [2:0] SEG_LOW_B = 3'b101;
  localparam logic [2:0] SEG_TOP   = 3'b111;

  logic [2:0] seg;
  logic [2:0] sub;
  logic       in_low_pair;
  logic       in_top;
  logic       in_user_win;

  always_comb begin
    seg         = addr[ADDR_W-1 -: 3];
    sub         = addr[ADDR_W-4 -: 3];
    in_low_pair = (seg == SEG_LOW_A) || (seg == SEG_LOW_B);
    in_top      = (seg == SEG_TOP);
    in_user_win = in_top && (sub == 3'b000);
    fixed_map   = in_low_pair || in_top;
    strip_top   = in_low_pair;
    user_block  = fixed_map && !priv && !in_user_win;
  end
endmodule

// File: rtl/mac_tlb_eval.sv
module mac_tlb_eval
  import mac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int SZ_W       = 2
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           is_wr,
  input  logic                           priv,
  input  logic                           hit,
  input  logic                           multi,
  input  logic [ADDR_W-3-PAGE_SHIFT-1:0] ppn,
  input  logic [SZ_W-1:0]                size,
  input  logic [1:0]                     prot,
  input  logic                           dirty,
  output logic [FC_W-1:0]                fault,
  output logic [ADDR_W-1:0]              pa,
  output perm_t                          perm
);
  localparam int PPN_W  = ADDR_W - 3 - PAGE_SHIFT;
  localparam int N_SIZE = 1 << SZ_W;

  logic [ADDR_W-1:0] off_mask [N_SIZE];

  genvar g;
  generate
    for (g = 0; g < N_SIZE; g++) begin : g_mask
      localparam int unsigned SHIFT = PAGE_SHIFT + size_extra(g);
      assign off_mask[g] = (ADDR_W'(1) << SHIFT) - ADDR_W'(1);
    end
  endgenerate

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] sel_mask;

  always_comb begin
    base     = {3'b000, ppn, {PAGE_SHIFT{1'b0}}};
    sel_mask = off_mask[size];
    fault    = FC_NONE;
    pa       = '0;
    perm     = PERM_NONE;
    if (multi) begin
      fault = FC_MULTI;
    end else if (!hit) begin
      fault = is_wr ? FC_WR_MISS : FC_RD_MISS;
    end else if (!priv && !prot[1]) begin
      fault = is_wr ? FC_WR_PROT : FC_RD_PROT;
    end else if (is_wr && !prot[0]) begin
      fault = FC_WR_PROT;
    end else if (is_wr && !dirty) begin
      fault = FC_FIRST_WR;
    end else begin
      pa     = (base & ~sel_mask) | (addr & sel_mask);
      perm.r = 1'b1;
      perm.x = 1'b1;
      perm.w = prot[0] && dirty;
    end
  end
endmodule

// File: rtl/mac_pteh_reg.sv
module mac_pteh_reg #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int ASID_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              capture,
  input  logic [ADDR_W-1:0] fault_addr,
  output logic [ADDR_W-1:0] q
);
  localparam int VPN_W = ADDR_W - PAGE_SHIFT;
  localparam int PAD_W = PAGE_SHIFT - ASID_W;

  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      asid_q <= '0;
    end else if (we) begin
      vpn_q  <= wdata[ADDR_W-1:PAGE_SHIFT];
      asid_q <= wdata[ASID_W-1:0];
    end else if (capture) begin
      vpn_q  <= fault_addr[ADDR_W-1:PAGE_SHIFT];
    end
  end

  assign q = {vpn_q, {PAD_W{1'b0}}, asid_q};
endmodule

// File: rtl/mac_addr_check.sv
module mac_addr_check
  import mac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int ASID_W     = 8,
  parameter int SZ_W       = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_valid,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic [1:0]                     acc_kind,
  input  logic                           priv_mode,
  input  logic                           xlat_en,
  input  logic                           tlb_hit,
  input  logic                           tlb_multi,
  input  logic [ADDR_W-3-PAGE_SHIFT-1:0] tlb_ppn,
  input  logic [SZ_W-1:0]                tlb_size,
  input  logic [1:0]                     tlb_prot,
  input  logic                           tlb_dirty,
  input  logic                           pteh_we,
  input  logic [ADDR_W-1:0]              pteh_wdata,
  output logic [ADDR_W-1:0]              pa,
  output logic                           pa_valid,
  output logic                           perm_r,
  output logic                           perm_w,
  output logic                           perm_x,
  output logic [11:0]                    fault_code,
  output logic [ADDR_W-1:0]              pteh
);
  localparam logic [ADDR_W-1:0] LOW_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

  acc_kind_e kind;
  logic      is_wr;
  logic      fixed_map;
  logic      strip_top;
  logic      user_block;

  logic [FC_W-1:0]   t_fault;
  logic [ADDR_W-1:0] t_pa;
  perm_t             t_perm;

  logic [FC_W-1:0]   fault_d;
  logic [ADDR_W-1:0] pa_d;
  perm_t             perm_d;
  logic              capture;

  assign kind  = acc_kind_e'(acc_kind);
  assign is_wr = (kind == ACC_WRITE);

  mac_region_dec #(.ADDR_W(ADDR_W)) u_region (
    .addr       (acc_addr),
    .priv       (priv_mode),
    .fixed_map  (fixed_map),
    .strip_top  (strip_top),
    .user_block (user_block)
  );

  mac_tlb_eval #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .SZ_W       (SZ_W)
  ) u_tlb_eval (
    .addr  (acc_addr),
    .is_wr (is_wr),
    .priv  (priv_mode),
    .hit   (tlb_hit),
    .multi (tlb_multi),
    .ppn   (tlb_ppn),
    .size  (tlb_size),
    .prot  (tlb_prot),
    .dirty (tlb_dirty),
    .fault (t_fault),
    .pa    (t_pa),
    .perm  (t_perm)
  );

  always_comb begin
    fault_d = FC_NONE;
    pa_d    = '0;
    perm_d  = PERM_NONE;
    if (acc_valid) begin
      if (user_block) begin
        fault_d = is_wr ? FC_WR_ADDR : FC_RD_ADDR;
      end else if (fixed_map) begin
        pa_d   = strip_top ? (acc_addr & LOW_MASK) : acc_addr;
        perm_d = PERM_ALL;
      end else if (!xlat_en) begin
        pa_d   = acc_addr & LOW_MASK;
        perm_d = PERM_ALL;
      end else begin
        fault_d = t_fault;
        pa_d    = t_pa;
        perm_d  = t_perm;
      end
    end
  end

  assign fault_code = fault_d;
  assign pa         = pa_d;
  assign perm_r     = perm_d.r;
  assign perm_w     = perm_d.w;
  assign perm_x     = perm_d.x;
  assign pa_valid   = acc_valid && (fault_d == FC_NONE);
  assign capture    = acc_valid && (fault_d != FC_NONE) && (fault_d != FC_MULTI);

  mac_pteh_reg #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ASID_W     (ASID_W)
  ) u_pteh (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (pteh_we),
    .wdata      (pteh_wdata),
    .capture    (capture),
    .fault_addr (acc_addr),
    .q          (pteh)
  );
endmodule

// File: rtl/mac_addr_check_sva.sv
module mac_addr_check_sva #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int ASID_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_kind,
  input logic              priv_mode,
  input logic              xlat_en,
  input logic              tlb_hit,
  input logic              tlb_multi,
  input logic [1:0]        tlb_prot,
  input logic              tlb_dirty,
  input logic              pteh_we,
  input logic [ADDR_W-1:0] pa,
  input logic              pa_valid,
  input logic              perm_r,
  input logic              perm_w,
  input logic              perm_x,
  input logic [11:0]       fault_code,
  input logic [ADDR_W-1:0] pteh
);
  logic       low_pair;
  logic       top_seg;
  logic       user_win;
  logic       xlat_region;
  assign low_pair    = (acc_addr[ADDR_W-1 -: 2] == 2'b10);
  assign top_seg     = (acc_addr[ADDR_W-1 -: 3] == 3'b111);
  assign user_win    = top_seg && (acc_addr[ADDR_W-4 -: 3] == 3'b000);
  assign xlat_region = !low_pair && !top_seg;

  AST_LOW_PAIR_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && priv_mode && low_pair |-> pa_valid && (pa[ADDR_W-1 -: 3] == 3'b000)
      && (pa[ADDR_W-4:0] == acc_addr[ADDR_W-4:0])); // R1

  AST_USER_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !priv_mode && (low_pair || (top_seg && !user_win))
      |-> fault_code == ((acc_kind == 2'b01) ? 12'h100 : 12'h0E0)); // R3

  AST_MULTI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && xlat_en && xlat_region && tlb_multi |-> fault_code == 12'h140); // R5

  AST_WRITE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && xlat_en && xlat_region && perm_w |-> tlb_hit && tlb_prot[0] && tlb_dirty); // R10

  AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 12'h000) || !acc_valid
      |-> !pa_valid && (pa == '0) && !perm_r && !perm_w && !perm_x); // R11

  AST_PTEH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (fault_code != 12'h000) && (fault_code != 12'h140) && !pteh_we
      |=> (pteh[ADDR_W-1:PAGE_SHIFT] == $past(acc_addr[ADDR_W-1:PAGE_SHIFT]))
        && (pteh[ASID_W-1:0] == $past(pteh[ASID_W-1:0]))); // R12

  AST_PTEH_MULTI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (fault_code == 12'h140) && !pteh_we |=> $stable(pteh)); // R12
endmodule

bind mac_addr_check mac_addr_check_sva #(
  .ADDR_W     (ADDR_W),
  .PAGE_SHIFT (PAGE_SHIFT),
  .ASID_W     (ASID_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .acc_kind   (acc_kind),
  .priv_mode  (priv_mode),
  .xlat_en    (xlat_en),
  .tlb_hit    (tlb_hit),
  .tlb_multi  (tlb_multi),
  .tlb_prot   (tlb_prot),
  .tlb_dirty  (tlb_dirty),
  .pteh_we    (pteh_we),
  .pa         (pa),
  .pa_valid   (pa_valid),
  .perm_r     (perm_r),
  .perm_w     (perm_w),
  .perm_x     (perm_x),
  .fault_code (fault_code),
  .pteh       (pteh)
);

// File: tb/mac_addr_check_tb.sv
module mac_addr_check_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        priv_mode = 1'b0;
  logic        xlat_en = 1'b0;
  logic        tlb_hit = 1'b0;
  logic        tlb_multi = 1'b0;
  logic [18:0] tlb_ppn = '0;
  logic [1:0]  tlb_size = '0;
  logic [1:0]  tlb_prot = '0;
  logic        tlb_dirty = 1'b0;
  logic        pteh_we = 1'b0;
  logic [31:0] pteh_wdata = '0;
  logic [31:0] pa;
  logic        pa_valid;
  logic        perm_r;
  logic        perm_w;
  logic        perm_x;
  logic [11:0] fault_code;
  logic [31:0] pteh;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_pteh = '0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mac_addr_check u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .priv_mode(priv_mode), .xlat_en(xlat_en),
    .tlb_hit(tlb_hit), .tlb_multi(tlb_multi), .tlb_ppn(tlb_ppn),
    .tlb_size(tlb_size), .tlb_prot(tlb_prot), .tlb_dirty(tlb_dirty),
    .pteh_we(pteh_we), .pteh_wdata(pteh_wdata), .pa(pa), .pa_valid(pa_valid),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .fault_code(fault_code), .pteh(pteh)
  );

  // behavioural reference from the requirement text
  task automatic model(output logic [11:0] f, output logic [31:0] p, output logic [2:0] rwx);
    bit wr;
    longint unsigned a, sz;
    wr = (acc_kind == 2'd1);
    a = acc_addr;
    f = 12'h000; p = 32'h0; rwx = 3'b000;
    if (!acc_valid) return;
    if ((a >= 64'h8000_0000 && a < 64'hC000_0000) || a >= 64'hE000_0000) begin
      if (!priv_mode && !(a >= 64'hE000_0000 && a < 64'hE400_0000))
        f = wr ? 12'h100 : 12'h0E0;
      else begin
        p = (a < 64'hC000_0000) ? 32'(a % 64'h2000_0000) : 32'(a);
        rwx = 3'b111;
      end
    end else if (!xlat_en) begin
      p = 32'(a % 64'h2000_0000);
      rwx = 3'b111;
    end else if (tlb_multi) f = 12'h140;
    else if (!tlb_hit) f = wr ? 12'h060 : 12'h040;
    else if (!priv_mode && !tlb_prot[1]) f = wr ? 12'h0C0 : 12'h0A0;
    else if (wr && !tlb_prot[0]) f = 12'h0C0;
    else if (wr && !tlb_dirty) f = 12'h080;
    else begin
      case (tlb_size)
        2'd0: sz = 1024;
        2'd1: sz = 4096;
        2'd2: sz = 65536;
        default: sz = 1048576;
      endcase
      p = 32'((longint'(tlb_ppn) * 1024 / sz) * sz + (a % sz));
      rwx = {1'b1, tlb_prot[0] && tlb_dirty, 1'b1};
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // inputs already set after a negedge; compare mid-low phase, then advance
  task automatic step(input string tag);
    logic [11:0] f;
    logic [31:0] p;
    logic [2:0] rwx;
    model(f, p, rwx);
    #(CLK_P/4);
    chk(tag, "fault", 32'(fault_code), 32'(f));
    chk(tag, "pa", pa, p);
    chk(tag, "perm", 32'({perm_r, perm_w, perm_x}), 32'(rwx));
    chk(tag, "pa_valid", 32'(pa_valid), 32'(acc_valid && f == 12'h000));
    chk("R12", "pteh", pteh, exp_pteh);
    @(posedge clk);
    if (pteh_we) exp_pteh = {pteh_wdata[31:10], 2'b00, pteh_wdata[7:0]};
    else if (acc_valid && f != 12'h000 && f != 12'h140) exp_pteh = {acc_addr[31:10], exp_pteh[9:0]};
    @(negedge clk);
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic pm, input logic xe);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k; priv_mode = pm; xlat_en = xe; pteh_we = 1'b0;
  endtask

  task automatic tlb(input logic h, input logic m, input logic [18:0] pp, input logic [1:0] s,
                     input logic [1:0] pr, input logic d);
    tlb_hit = h; tlb_multi = m; tlb_ppn = pp; tlb_size = s; tlb_prot = pr; tlb_dirty = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R11"); // reset state, idle
    pteh_we = 1'b1; pteh_wdata = 32'h1234_56AB; step("R12");
    // R1: low pair privileged, TLB ignored
    tlb(1'b0, 1'b1, 19'h7FFFF, 2'd3, 2'b00, 1'b0);
    acc(32'h8000_0000, 2'd1, 1'b1, 1'b1); step("R1");
    acc(32'hBFFF_FFFF, 2'd2, 1'b1, 1'b0); step("R1");
    acc(32'hA123_4567, 2'd0, 1'b1, 1'b1); step("R1");
    // R2: top region privileged and user window
    acc(32'hE000_0000, 2'd1, 1'b1, 1'b1); step("R2");
    acc(32'hFFFF_FFFC, 2'd0, 1'b1, 1'b1); step("R2");
    acc(32'hE3FF_FFFF, 2'd1, 1'b0, 1'b1); step("R2");
    acc(32'hE000_0010, 2'd2, 1'b0, 1'b1); step("R2");
    // R3: user address errors
    acc(32'hE400_0000, 2'd0, 1'b0, 1'b1); step("R3");
    acc(32'hE400_0000, 2'd1, 1'b0, 1'b1); step("R3");
    acc(32'h8000_1000, 2'd2, 1'b0, 1'b0); step("R3");
    acc(32'hBFFF_FFFF, 2'd3, 1'b0, 1'b1); step("R3");
    acc(32'hFFFF_F000, 2'd1, 1'b0, 1'b0); step("R3");
    // R4: translation off
    acc(32'h7FFF_FFFF, 2'd1, 1'b0, 1'b0); step("R4");
    acc(32'hC000_0000, 2'd0, 1'b1, 1'b0); step("R4");
    acc(32'hDFFF_FFFF, 2'd2, 1'b0, 1'b0); step("R4");
    // R5: multiple hit takes priority
    tlb(1'b0, 1'b1, 19'h00010, 2'd0, 2'b00, 1'b0);
    acc(32'h0000_4400, 2'd1, 1'b0, 1'b1); step("R5");
    tlb(1'b1, 1'b1, 19'h00010, 2'd0, 2'b11, 1'b1);
    acc(32'hC000_0400, 2'd0, 1'b1, 1'b1); step("R5");
    // R6: miss
    tlb(1'b0, 1'b0, 19'h00010, 2'd0, 2'b00, 1'b0);
    acc(32'h1234_5678, 2'd0, 1'b1, 1'b1); step("R6");
    acc(32'h1234_5678, 2'd1, 1'b1, 1'b1); step("R6");
    acc(32'h0ABC_0000, 2'd2, 1'b0, 1'b1); step("R6");
    // R7: user protection
    tlb(1'b1, 1'b0, 19'h00020, 2'd1, 2'b01, 1'b1);
    acc(32'h0040_0000, 2'd0, 1'b0, 1'b1); step("R7");
    acc(32'h0040_0000, 2'd1, 1'b0, 1'b1); step("R7");
    acc(32'h0040_0000, 2'd2, 1'b0, 1'b1); step("R7");
    acc(32'h0040_0123, 2'd0, 1'b1, 1'b1); step("R7"); // privileged passes
    // R8: write permission then dirty
    tlb(1'b1, 1'b0, 19'h00020, 2'd1, 2'b10, 1'b0);
    acc(32'h0040_0000, 2'd1, 1'b0, 1'b1); step("R8");
    tlb(1'b1, 1'b0, 19'h00020, 2'd1, 2'b11, 1'b0);
    acc(32'h0040_0000, 2'd1, 1'b0, 1'b1); step("R8");
    acc(32'h0040_0000, 2'd0, 1'b0, 1'b1); step("R8"); // read unaffected by dirty
    // R9: page sizes
    for (int s = 0; s < 4; s++) begin
      tlb(1'b1, 1'b0, 19'h5A5A5, 2'(s), 2'b11, 1'b1);
      acc(32'h3FFF_FFFF, 2'd0, 1'b0, 1'b1); step("R9");
      acc(32'h0000_0000, 2'd1, 1'b1, 1'b1); step("R9");
    end
    // R10: write grant
    tlb(1'b1, 1'b0, 19'h00123, 2'd0, 2'b10, 1'b1);
    acc(32'h0000_0200, 2'd0, 1'b0, 1'b1); step("R10");
    tlb(1'b1, 1'b0, 19'h00123, 2'd0, 2'b11, 1'b0);
    acc(32'h0000_0200, 2'd2, 1'b0, 1'b1); step("R10");
    tlb(1'b1, 1'b0, 19'h00123, 2'd0, 2'b11, 1'b1);
    acc(32'h0000_0200, 2'd0, 1'b0, 1'b1); step("R10");
    // R11: idle with faulting inputs
    tlb(1'b0, 1'b0, 19'h0, 2'd0, 2'b00, 1'b0);
    acc(32'h0000_1000, 2'd1, 1'b0, 1'b1); acc_valid = 1'b0; step("R11");
    // R12: write priority over capture, multi holds
    acc(32'hFEDC_B800, 2'd0, 1'b0, 1'b1);
    pteh_we = 1'b1; pteh_wdata = 32'hCAFE_F3C5; step("R12");
    tlb(1'b0, 1'b1, 19'h0, 2'd0, 2'b00, 1'b0);
    acc(32'h0101_0400, 2'd0, 1'b0, 1'b1); step("R12");
    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      tlb(r[0], r[1] & r[2], 19'($urandom), r[4:3], r[6:5], r[7]);
      acc($urandom, r[9:8], r[10], r[11] | r[12]);
      acc_valid = r[13] | r[14] | r[15];
      pteh_we = (r[19:16] == 4'd0);
      pteh_wdata = $urandom;
      step("R9");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule